// File: doc/BRIEF.md
# Branch History Ring

This block keeps a short hardware history of the most recent taken control transfers: branches, interrupts and exceptions. An upstream pipeline presents each transfer on a one-cycle event strobe. The strobe carries the source address, the destination address, the current privilege level (0 is the most privileged kernel level, 3 the least privileged user level) and a flag that says whether the core runs in 64-bit mode. When an event is accepted, the block stores it as a from/to pair in a ring of 32 entries. A head pointer always names the entry that holds the newest pair.

Software reaches the block through a register-mapped port with a 12-bit register number. Through this port it switches recording on and off, selects which privilege levels are dropped, and reads or rewrites the head pointer and every stored pair. After the ring has been enabled, software reads the head pointer and then walks backwards through the entries to rebuild the recent control flow.

Top module: `branch_ring`

## Requirements
- R1: After reset, the enable register, the filter register, the head pointer and every from/to entry all read as zero.
- R2: While bit 0 of the enable register (number 0x1D9) is 0, branch events are ignored: the head pointer and the entries do not change.
- R3: On each accepted event, the head pointer advances by one modulo 32. In the same cycle, the source and destination addresses are written into the entry the new pointer names. The pointer wraps from 31 to 0.
- R4: Register map. The filter register is at 0x1C8 and reads back its bits [1:0]. The head pointer is at 0x1C9 in bits [4:0]. The enable register is at 0x1D9 and reads back bit 0. From-address entry k is at 0x680+k, and to-address entry k is at 0x6C0+k.
- R5: When the 64-bit-mode flag is 1, the full 64-bit addresses are stored. When it is 0, bits [63:32] of both stored addresses are zero and bits [31:0] are kept.
- R6: When bit 0 of the filter register is 1, events at privilege level 0 are not recorded.
- R7: When bit 1 of the filter register is 1, events at privilege levels 1, 2 and 3 are not recorded. When both filter bits are 1, no event is recorded.
- R8: Software writes to the head pointer and to any from/to entry overwrite the stored value.
- R9: If an accepted event and a software write target the same pointer or entry in the same cycle, the event's value is the one kept.
- R10: A read request returns its data and a valid strobe exactly one cycle later. The data is the state before that cycle's updates. Reads of unmapped register numbers return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Branch event strobe |
| ev_src | input | 64 | Source address of the transfer |
| ev_dst | input | 64 | Destination address of the transfer |
| ev_cpl | input | 2 | Privilege level of the event |
| ev_long | input | 1 | 1 when the core runs in 64-bit mode |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register number |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |

## Verification
A faulty head pointer is visible at 0x1C9 on the very next read. A skipped or doubled increment shifts every later entry, so a wrong pointer also shows up at the from/to addresses a read later. A faulty filter or enable decision shows up as a pointer that moves when it should hold, or holds when it should move, one cycle after the event. Wrong address masking or a wrong arbitration outcome appears as wrong upper or whole data when the entry is read back.

// File: rtl/brr_pkg.sv
package brr_pkg;
    localparam logic [11:0] REG_FILTER = 12'h1C8;
    localparam logic [11:0] REG_HEAD   = 12'h1C9;
    localparam logic [11:0] REG_ENABLE = 12'h1D9;
    localparam logic [11:0] REG_FROM0  = 12'h680;
    localparam logic [11:0] REG_TO0    = 12'h6C0;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_ENABLE, TGT_FILTER, TGT_HEAD, TGT_FROM, TGT_TO
    } tgt_e;
endpackage

// File: rtl/brr_filter.sv
module brr_filter (
    input  logic       ev_valid,
    input  logic       enable,
    input  logic [1:0] filter,
    input  logic [1:0] ev_cpl,
    output logic       accept
);
    logic kernel;
    always_comb begin
        kernel = (ev_cpl == 2'd0);
        accept = ev_valid && enable
              && !(kernel && filter[0])
              && !(!kernel && filter[1]);
    end
endmodule

// File: rtl/brr_ptr.sv
module brr_ptr #(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_val,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] head_nx
);
    always_comb head_nx = head + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n)      head <= '0;
        else if (step)   head <= head_nx;
        else if (sw_we)  head <= sw_val;
    end
endmodule

// File: rtl/brr_store.sv
module brr_store #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 64,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int HALF  = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_we,
    input  logic              ev_long,
    input  logic [IDX_W-1:0]  ev_idx,
    input  logic [ADDR_W-1:0] ev_from,
    input  logic [ADDR_W-1:0] ev_to,
    input  logic              sw_we_from,
    input  logic              sw_we_to,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [ADDR_W-1:0] sw_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_from,
    output logic [ADDR_W-1:0] rd_to
);
    logic [ADDR_W-1:0] from_mem [DEPTH];
    logic [ADDR_W-1:0] to_mem   [DEPTH];
    logic [ADDR_W-1:0] from_in, to_in;

    always_comb begin
        from_in = ev_long ? ev_from : {{HALF{1'b0}}, ev_from[HALF-1:0]};
        to_in   = ev_long ? ev_to   : {{HALF{1'b0}}, ev_to[HALF-1:0]};
        rd_from = from_mem[rd_idx];
        rd_to   = to_mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                from_mem[k] <= '0;
                to_mem[k]   <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (ev_we && ev_idx == IDX_W'(k)) begin
                    from_mem[k] <= from_in;
                    to_mem[k]   <= to_in;
                end else begin
                    if (sw_we_from && sw_idx == IDX_W'(k)) from_mem[k] <= sw_data;
                    if (sw_we_to   && sw_idx == IDX_W'(k)) to_mem[k]   <= sw_data;
                end
            end
        end
    end

    // R5: short-mode records keep the upper half clear
    assert_hi_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_we && !ev_long) |=> (from_mem[$past(ev_idx)][ADDR_W-1:HALF] == '0
                               && to_mem[$past(ev_idx)][ADDR_W-1:HALF] == '0));
    // R9: the event data survives a same-cycle software write to its entry
    assert_ev_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_we && ev_long && sw_we_from && sw_idx == ev_idx)
            |=> (from_mem[$past(ev_idx)] == $past(ev_from)));
endmodule

// File: rtl/branch_ring.sv
module branch_ring #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 64,
    parameter int REG_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [ADDR_W-1:0] ev_src,
    input  logic [ADDR_W-1:0] ev_dst,
    input  logic [1:0]        ev_cpl,
    input  logic              ev_long,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              reg_rvalid
);
    import brr_pkg::*;
    localparam int IDX_W = $clog2(DEPTH);

    logic              enable_q;
    logic [1:0]        filter_q;
    logic              accept;
    logic [IDX_W-1:0]  head, head_nx, slot;
    logic [ADDR_W-1:0] rd_from, rd_to, rd_mux;
    tgt_e              tgt;

    always_comb begin
        tgt  = TGT_NONE;
        slot = '0;
        if (reg_addr == REG_ENABLE)      tgt = TGT_ENABLE;
        else if (reg_addr == REG_FILTER) tgt = TGT_FILTER;
        else if (reg_addr == REG_HEAD)   tgt = TGT_HEAD;
        else if (reg_addr >= REG_FROM0 && reg_addr < REG_FROM0 + REG_W'(DEPTH)) begin
            tgt  = TGT_FROM;
            slot = IDX_W'(reg_addr - REG_FROM0);
        end else if (reg_addr >= REG_TO0 && reg_addr < REG_TO0 + REG_W'(DEPTH)) begin
            tgt  = TGT_TO;
            slot = IDX_W'(reg_addr - REG_TO0);
        end
    end

    brr_filter u_filter (
        .ev_valid (ev_valid),
        .enable   (enable_q),
        .filter   (filter_q),
        .ev_cpl   (ev_cpl),
        .accept   (accept)
    );

    brr_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (accept),
        .sw_we   (reg_wr && tgt == TGT_HEAD),
        .sw_val  (reg_wdata[IDX_W-1:0]),
        .head    (head),
        .head_nx (head_nx)
    );

    brr_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_we      (accept),
        .ev_long    (ev_long),
        .ev_idx     (head_nx),
        .ev_from    (ev_src),
        .ev_to      (ev_dst),
        .sw_we_from (reg_wr && tgt == TGT_FROM),
        .sw_we_to   (reg_wr && tgt == TGT_TO),
        .sw_idx     (slot),
        .sw_data    (reg_wdata),
        .rd_idx     (slot),
        .rd_from    (rd_from),
        .rd_to      (rd_to)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            filter_q <= 2'b00;
        end else if (reg_wr) begin
            if (tgt == TGT_ENABLE) enable_q <= reg_wdata[0];
            if (tgt == TGT_FILTER) filter_q <= reg_wdata[1:0];
        end
    end

    always_comb begin
        unique case (tgt)
            TGT_ENABLE: rd_mux = {{(ADDR_W-1){1'b0}}, enable_q};
            TGT_FILTER: rd_mux = {{(ADDR_W-2){1'b0}}, filter_q};
            TGT_HEAD:   rd_mux = ADDR_W'(head);
            TGT_FROM:   rd_mux = rd_from;
            TGT_TO:     rd_mux = rd_to;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= reg_rd;
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    assert_head_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (head == IDX_W'($past(head) + 1'b1)));
    assert_head_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable_q && !(reg_wr && tgt == TGT_HEAD)) |=> $stable(head));
    assert_kernel_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_q[0] && ev_cpl == 2'd0 && !(reg_wr && tgt == TGT_HEAD)) |=> $stable(head));
    assert_user_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (filter_q[1] && ev_cpl != 2'd0 && !(reg_wr && tgt == TGT_HEAD)) |=> $stable(head));
    assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);
    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !reg_rvalid);
endmodule

// File: tb/branch_ring_tb.sv
module branch_ring_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0;
    logic [63:0] ev_src = '0, ev_dst = '0;
    logic [1:0]  ev_cpl = '0;
    logic        ev_long = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        reg_rvalid;

    int total = 0;
    int bad = 0;
    int mptr = 0;

    always #10 clk = ~clk;

    branch_ring u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_src(ev_src),
        .ev_dst(ev_dst), .ev_cpl(ev_cpl), .ev_long(ev_long), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    // {enable, filter[1:0], cpl[1:0], long, expected_recorded}
    localparam logic [6:0] VECS [12] = '{
        7'b1_00_11_1_1, 7'b1_00_00_1_1, 7'b1_00_10_0_1, 7'b0_00_11_1_0,
        7'b1_01_00_1_0, 7'b1_01_11_1_1, 7'b1_10_11_0_0, 7'b1_10_00_0_1,
        7'b1_11_00_1_0, 7'b1_11_01_1_0, 7'b1_10_01_1_0, 7'b1_01_01_0_1
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
        chk("R10 rvalid", {63'b0, reg_rvalid}, 64'd1);
    endtask

    task automatic ev(input logic [63:0] s, input logic [63:0] d, input logic [1:0] c, input logic l);
        @(negedge clk);
        ev_valid = 1'b1; ev_src = s; ev_dst = d; ev_cpl = c; ev_long = l;
        @(negedge clk);
        ev_valid = 1'b0;
    endtask

    task automatic ev_and_wr(input logic [63:0] s, input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        ev_valid = 1'b1; ev_src = s; ev_dst = ~s; ev_cpl = 2'd3; ev_long = 1'b1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        ev_valid = 1'b0; reg_wr = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(12'h1D9, v); chk("R1 enable", v, 64'd0);
        rd(12'h1C8, v); chk("R1 filter", v, 64'd0);
        rd(12'h1C9, v); chk("R1 head", v, 64'd0);
        rd(12'h680, v); chk("R1 from0", v, 64'd0);
        rd(12'h6DF, v); chk("R1 to31", v, 64'd0);

        // R4 readback of control registers
        wr(12'h1D9, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h1D9, v); chk("R4 enable", v, 64'd1);
        wr(12'h1C8, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h1C8, v); chk("R4 filter", v, 64'd3);

        // Vector table: R2, R3, R5, R6, R7
        for (int i = 0; i < 12; i++) begin
            logic [6:0]  vec;
            logic [63:0] s, d, es, ed;
            vec = VECS[i];
            s = {32'hF0F0_0000 + 32'(i), 32'h1000_0000 + 32'(i)};
            d = {32'h0BAD_0000 + 32'(i), 32'h2000_0000 + 32'(i)};
            wr(12'h1D9, {63'b0, vec[6]});
            wr(12'h1C8, {62'b0, vec[5:4]});
            ev(s, d, vec[3:2], vec[1]);
            if (vec[0]) mptr = (mptr + 1) % 32;
            rd(12'h1C9, v); chk("R2 R3 R6 R7 head", v, 64'(mptr));
            if (vec[0]) begin
                es = vec[1] ? s : {32'b0, s[31:0]};
                ed = vec[1] ? d : {32'b0, d[31:0]};
                rd(12'h680 + 12'(mptr), v); chk("R3 R4 R5 from", v, es);
                rd(12'h6C0 + 12'(mptr), v); chk("R3 R4 R5 to", v, ed);
            end
        end

        // R8 software overwrite, R3 wrap 31 -> 0
        wr(12'h1D9, 64'd1);
        wr(12'h1C8, 64'd0);
        wr(12'h685, 64'h1234_5678_9ABC_DEF0);
        rd(12'h685, v); chk("R8 from5", v, 64'h1234_5678_9ABC_DEF0);
        wr(12'h1C9, 64'd31);
        rd(12'h1C9, v); chk("R8 head", v, 64'd31);
        ev(64'hCAFE_0000_0000_0001, 64'hCAFE_0000_0000_0002, 2'd0, 1'b1);
        rd(12'h1C9, v); chk("R3 wrap head", v, 64'd0);
        rd(12'h680, v); chk("R3 wrap from0", v, 64'hCAFE_0000_0000_0001);
        rd(12'h6C0, v); chk("R3 wrap to0", v, 64'hCAFE_0000_0000_0002);
        mptr = 0;

        // R9 event versus same-cycle software write
        ev_and_wr(64'h7777_0000_0000_0001, 12'h1C9, 64'd20);
        mptr = 1;
        rd(12'h1C9, v); chk("R9 head", v, 64'd1);
        ev_and_wr(64'h8888_0000_0000_0002, 12'h682, 64'hDEAD_BEEF);
        mptr = 2;
        rd(12'h682, v); chk("R9 from", v, 64'h8888_0000_0000_0002);

        // R10 unmapped reads
        rd(12'h000, v); chk("R10 unmapped 0x000", v, 64'd0);
        rd(12'h6A0, v); chk("R10 unmapped 0x6A0", v, 64'd0);
        @(negedge clk);
        chk("R10 rvalid idle", {63'b0, reg_rvalid}, 64'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule